// File: doc/BRIEF.md
# Interrupt Command Error Checker

This block screens each write to the inter-processor interrupt command register before anything is sent. A command word holds an 8-bit vector in bits 7:0 and a 3-bit delivery mode in bits 10:8. A command is accepted only when its vector is 16 or above and its delivery mode is not lowest priority. An accepted command leaves as a one-cycle send request that carries the vector, the mode and the addressing-mode flag. A rejected command is never sent. Instead it leaves a sticky error bit behind.

Errors gather in an internal accumulator. Two external event inputs also feed it: one for a received illegal vector and one for an illegal register access. Software sees the errors through a separate readable status word. A write to the status register copies the accumulator into that word and clears the accumulator on the same clock edge. The lowest-priority check comes first. It masks the vector check, so a command with both faults reports only the redirection error.

Top module: `ipi_cmd_guard`

## Requirements
- R1: A command write whose delivery mode (bits 10:8) equals 3'b001 (lowest priority) sets status bit 4 and produces no send request.
- R2: The R1 rule behaves the same whether the addressing-mode input is 0 (legacy) or 1 (extended).
- R3: A command with lowest-priority mode and a vector below 16 sets only bit 4; bit 5 stays clear.
- R4: A command with any other delivery mode and a vector (bits 7:0) below 16 sets status bit 5 and produces no send request.
- R5: A command with a vector of 16 or more and a delivery mode other than 3'b001 raises the send request for exactly one cycle, on the cycle after the write, carrying the vector, mode and addressing flag of that write.
- R6: The received-illegal-vector event sets bit 6 and the illegal-register event sets bit 7 on any cycle, with or without a command write.
- R7: Error bits are sticky: they OR together in the accumulator until a status write occurs.
- R8: A status write loads the readable word with the accumulator as it stood before that edge and clears the accumulator. Errors that arrive in the same cycle land in the cleared accumulator and are not lost.
- R9: Bits 3:0 and 31:8 of the readable status word always read zero.
- R10: A synchronous active-high reset clears the accumulator, the readable word and the send request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_word | input | 11 | Command: vector in 7:0, delivery mode in 10:8 |
| ext_mode | input | 1 | Addressing mode: 1 extended, 0 legacy |
| stat_we | input | 1 | Status register write strobe |
| rx_bad_vec | input | 1 | Received-illegal-vector event |
| bad_reg_acc | input | 1 | Illegal-register-access event |
| send_vld | output | 1 | One-cycle send request for an accepted command |
| send_vec | output | 8 | Vector of the accepted command |
| send_mode | output | 3 | Delivery mode of the accepted command |
| send_ext | output | 1 | Addressing mode of the accepted command |
| stat_word | output | 32 | Readable error status word |

## Verification
The delicate overlap is a status write in the same cycle that a new error arises, whether from a rejected command or an event input. The snapshot must take the earlier accumulator while the new bit survives into the next one. The random phase makes status writes, command writes and both event inputs frequent enough that all four coincide often. A directed case also places an event pulse exactly on a status write. A bench model, built from the requirements, predicts both the snapshot and the following read, and each is compared at the ports.

// File: rtl/ipi_guard_pkg.sv
package ipi_guard_pkg;
    localparam int VEC_W   = 8;
    localparam int MODE_W  = 3;
    localparam int CMD_W   = VEC_W + MODE_W;
    localparam int STAT_W  = 32;
    localparam int MIN_VEC = 16;
    localparam int ERR_LSB = 4;
    localparam logic [MODE_W-1:0] DM_LOWPRI = 3'b001;

    // field order matches status bits 7:4
    typedef struct packed {
        logic reg_bad;
        logic rx_bad;
        logic send_bad;
        logic redir;
    } err_t;

    localparam int ERR_W = $bits(err_t);
endpackage

// File: rtl/ipi_cmd_classify.sv
module ipi_cmd_classify
    import ipi_guard_pkg::*;
(
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             hit_redir,
    output logic             hit_badvec,
    output logic             accept
);
    logic [VEC_W-1:0]  vec;
    logic [MODE_W-1:0] mode;
    logic              vec_low;

    always_comb begin
        vec        = cmd_word[VEC_W-1:0];
        mode       = cmd_word[CMD_W-1:VEC_W];
        vec_low    = (int'(vec) < MIN_VEC);
        // lowest-priority check has precedence over the vector check
        hit_redir  = cmd_we && (mode == DM_LOWPRI);
        hit_badvec = cmd_we && !hit_redir && vec_low;
        accept     = cmd_we && !hit_redir && !vec_low;
    end
endmodule

// File: rtl/ipi_err_accum.sv
module ipi_err_accum
    import ipi_guard_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  err_t err_set,
    input  logic stat_we,
    output err_t acc,
    output err_t stat
);
    typedef struct packed {
        err_t acc;
        err_t stat;
    } accum_state_t;

    accum_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = stat_we ? st_q.acc : st_q.stat;
        st_d.acc  = (stat_we ? '0 : st_q.acc) | err_set;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc  = st_q.acc;
    assign stat = st_q.stat;
endmodule

// File: rtl/ipi_send_reg.sv
module ipi_send_reg
    import ipi_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              ext_mode,
    output logic              send_vld,
    output logic [VEC_W-1:0]  send_vec,
    output logic [MODE_W-1:0] send_mode,
    output logic              send_ext
);
    typedef struct packed {
        logic              vld;
        logic [VEC_W-1:0]  vec;
        logic [MODE_W-1:0] mode;
        logic              ext;
    } send_state_t;

    send_state_t sr_d, sr_q;

    always_comb begin
        sr_d     = sr_q;
        sr_d.vld = accept;
        if (accept) begin
            sr_d.vec  = cmd_word[VEC_W-1:0];
            sr_d.mode = cmd_word[CMD_W-1:VEC_W];
            sr_d.ext  = ext_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= sr_d;
    end

    assign send_vld  = sr_q.vld;
    assign send_vec  = sr_q.vec;
    assign send_mode = sr_q.mode;
    assign send_ext  = sr_q.ext;
endmodule

// File: rtl/ipi_cmd_guard.sv
module ipi_cmd_guard
    import ipi_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              ext_mode,
    input  logic              stat_we,
    input  logic              rx_bad_vec,
    input  logic              bad_reg_acc,
    output logic              send_vld,
    output logic [VEC_W-1:0]  send_vec,
    output logic [MODE_W-1:0] send_mode,
    output logic              send_ext,
    output logic [STAT_W-1:0] stat_word
);
    logic hit_redir, hit_badvec, accept;
    err_t err_set, acc, stat;

    ipi_cmd_classify u_classify (
        .cmd_we     (cmd_we),
        .cmd_word   (cmd_word),
        .hit_redir  (hit_redir),
        .hit_badvec (hit_badvec),
        .accept     (accept)
    );

    always_comb begin
        err_set.redir    = hit_redir;
        err_set.send_bad = hit_badvec;
        err_set.rx_bad   = rx_bad_vec;
        err_set.reg_bad  = bad_reg_acc;
    end

    ipi_err_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .err_set (err_set),
        .stat_we (stat_we),
        .acc     (acc),
        .stat    (stat)
    );

    ipi_send_reg u_send (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .cmd_word  (cmd_word),
        .ext_mode  (ext_mode),
        .send_vld  (send_vld),
        .send_vec  (send_vec),
        .send_mode (send_mode),
        .send_ext  (send_ext)
    );

    always_comb begin
        stat_word = '0;
        stat_word[ERR_LSB +: ERR_W] = stat;
    end
endmodule

// File: rtl/ipi_cmd_guard_chk.sv
module ipi_cmd_guard_chk
    import ipi_guard_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_we,
    input logic [CMD_W-1:0]  cmd_word,
    input logic              stat_we,
    input logic              rx_bad_vec,
    input logic              bad_reg_acc,
    input logic              send_vld,
    input logic [VEC_W-1:0]  send_vec,
    input err_t              acc,
    input logic [STAT_W-1:0] stat_word
);
    logic is_lp, is_low;
    assign is_lp  = cmd_word[CMD_W-1:VEC_W] == DM_LOWPRI;
    assign is_low = int'(cmd_word[VEC_W-1:0]) < MIN_VEC;

    // R1
    redir_block_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we && is_lp |=> acc.redir && !send_vld);

    // R3
    redir_masks_vec_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we && is_lp && stat_we |=> !acc.send_bad);

    // R4
    bad_vec_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we && !is_lp && is_low |=> acc.send_bad && !send_vld);

    // R5
    send_src_chk: assert property (@(posedge clk) disable iff (rst)
        send_vld |-> $past(cmd_we) && send_vec == $past(cmd_word[VEC_W-1:0]));

    // R6
    rx_event_chk: assert property (@(posedge clk) disable iff (rst)
        rx_bad_vec |=> acc.rx_bad);

    // R6
    reg_event_chk: assert property (@(posedge clk) disable iff (rst)
        bad_reg_acc |=> acc.reg_bad);

    // R8
    snapshot_chk: assert property (@(posedge clk) disable iff (rst)
        stat_we |=> stat_word[ERR_LSB +: ERR_W] == $past(acc));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        stat_word[ERR_LSB-1:0] == '0 && stat_word[STAT_W-1:ERR_LSB+ERR_W] == '0);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> stat_word == '0 && acc == '0 && !send_vld);
endmodule

bind ipi_cmd_guard ipi_cmd_guard_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_we      (cmd_we),
    .cmd_word    (cmd_word),
    .stat_we     (stat_we),
    .rx_bad_vec  (rx_bad_vec),
    .bad_reg_acc (bad_reg_acc),
    .send_vld    (send_vld),
    .send_vec    (send_vec),
    .acc         (acc),
    .stat_word   (stat_word)
);

// File: tb/ipi_cmd_guard_tb.sv
module ipi_cmd_guard_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_we;
    logic [10:0] cmd_word;
    logic        ext_mode;
    logic        stat_we;
    logic        rx_bad_vec;
    logic        bad_reg_acc;
    logic        send_vld;
    logic [7:0]  send_vec;
    logic [2:0]  send_mode;
    logic        send_ext;
    logic [31:0] stat_word;

    int n_chk = 0;
    int n_bad = 0;

    logic [3:0]  m_acc, m_stat;
    logic        m_vld, m_ext;
    logic [7:0]  m_vec;
    logic [2:0]  m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_cmd_guard u_dut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_word(cmd_word),
        .ext_mode(ext_mode), .stat_we(stat_we), .rx_bad_vec(rx_bad_vec),
        .bad_reg_acc(bad_reg_acc), .send_vld(send_vld), .send_vec(send_vec),
        .send_mode(send_mode), .send_ext(send_ext), .stat_word(stat_word)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] stat_of(logic [3:0] e);
        return {24'h0, e, 4'h0};
    endfunction

    // one cycle: drive at negedge, model, wait edge, compare at next negedge
    task automatic step(logic we, logic [2:0] mode, logic [7:0] vec, logic ext,
                        logic swe, logic rxb, logic regb);
        logic lp, low, ok;
        logic [3:0] set;
        cmd_we = we; cmd_word = {mode, vec}; ext_mode = ext;
        stat_we = swe; rx_bad_vec = rxb; bad_reg_acc = regb;
        lp  = we && mode == 3'b001;
        low = vec < 8'd16;
        ok  = we && !lp && !low;
        set = {regb, rxb, we && !lp && low, lp};
        if (swe) m_stat = m_acc;
        m_acc = (swe ? 4'h0 : m_acc) | set;
        m_vld = ok;
        if (ok) begin m_vec = vec; m_mode = mode; m_ext = ext; end
        @(posedge clk);
        @(negedge clk);
        chk("R5 send_vld", {31'h0, send_vld}, {31'h0, m_vld});
        if (m_vld) chk("R5 payload", {20'h0, send_ext, send_mode, send_vec},
                       {20'h0, m_ext, m_mode, m_vec});
        chk("R8 stat_word", stat_word, stat_of(m_stat));
        chk("R9 reserved", stat_word & 32'hFFFF_FF0F, 32'h0);
    endtask

    task automatic idle(); step(0, 3'd0, 8'd0, 0, 0, 0, 0); endtask
    task automatic snap(); step(0, 3'd0, 8'd0, 0, 1, 0, 0); endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; cmd_we = 0; cmd_word = '0; ext_mode = 0;
        stat_we = 0; rx_bad_vec = 0; bad_reg_acc = 0;
        m_acc = 0; m_stat = 0; m_vld = 0; m_vec = 0; m_mode = 0; m_ext = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 stat after reset", stat_word, 32'h0);
        chk("R10 send after reset", {31'h0, send_vld}, 32'h0);
        rst = 0;

        // R1 lowest priority, legacy addressing
        step(1, 3'b001, 8'h40, 0, 0, 0, 0);
        chk("R1 no send", {31'h0, send_vld}, 32'h0);
        snap();
        chk("R1 bit4", stat_word, 32'h10);
        // R2 same rule with extended addressing
        step(1, 3'b001, 8'h40, 1, 0, 0, 0);
        chk("R2 no send ext", {31'h0, send_vld}, 32'h0);
        snap();
        chk("R2 bit4 ext", stat_word, 32'h10);
        // R3 both faults: only bit4
        step(1, 3'b001, 8'h05, 0, 0, 0, 0);
        snap();
        chk("R3 only redir", stat_word, 32'h10);
        // R4 illegal vector, fixed mode
        step(1, 3'b000, 8'h05, 0, 0, 0, 0);
        chk("R4 no send", {31'h0, send_vld}, 32'h0);
        snap();
        chk("R4 bit5", stat_word, 32'h20);
        // R4 boundary: vector 15 illegal, 16 legal
        step(1, 3'b100, 8'd15, 0, 0, 0, 0);
        chk("R4 vec15 no send", {31'h0, send_vld}, 32'h0);
        step(1, 3'b100, 8'd16, 1, 0, 0, 0);
        chk("R5 vec16 sent", {31'h0, send_vld}, 32'h1);
        // R5 accepted command, one-cycle pulse
        step(1, 3'b000, 8'h30, 1, 0, 0, 0);
        chk("R5 pulse", {20'h0, send_ext, send_mode, send_vld, send_vec},
            {20'h0, 1'b1, 3'b000, 1'b1, 8'h30});
        idle();
        chk("R5 pulse ends", {31'h0, send_vld}, 32'h0);
        snap();
        // R6/R7 events without commands, sticky accumulation
        step(0, 3'd0, 8'd0, 0, 0, 1, 0);
        idle();
        step(0, 3'd0, 8'd0, 0, 0, 0, 1);
        idle();
        snap();
        chk("R6 R7 bits 7:6 sticky", stat_word, 32'hC0);
        // R8 event in the same cycle as the status write
        step(0, 3'd0, 8'd0, 0, 1, 1, 0);
        chk("R8 snapshot old acc", stat_word, 32'h0);
        snap();
        chk("R8 new event kept", stat_word, 32'h40);
        // R8 command error on the status-write cycle
        step(1, 3'b000, 8'h02, 0, 1, 0, 1);
        snap();
        chk("R8 cmd err kept", stat_word, 32'hA0);

        // random phase with frequent overlaps
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] md;
            logic [7:0] vc;
            md = ($urandom_range(0, 2) == 0) ? 3'b001 : 3'($urandom);
            vc = ($urandom_range(0, 2) == 0) ? 8'($urandom_range(0, 15)) : 8'($urandom);
            step($urandom_range(0, 1) == 1, md, vc, 1'($urandom),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0,
                 $urandom_range(0, 5) == 0);
        end

        // R10 reset mid-run clears everything
        step(0, 3'd0, 8'd0, 0, 0, 1, 1);
        rst = 1;
        @(negedge clk);
        rst = 0;
        m_acc = 0; m_stat = 0; m_vld = 0;
        snap();
        chk("R10 acc cleared", stat_word, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule